// File: doc/BRIEF.md
# Bridge PWM Output Steering Stage

This block turns a 10-bit duty value and an externally running period timer into the drive for a four-leg output stage (legs A, B, C, D). One pulse-width-modulated signal is made from the timer count. It is then routed by a 2-bit bridge configuration. In single mode it goes onto any subset of the legs chosen by a steering mask. In forward and reverse full-bridge modes one leg is modulated and the others sit at fixed levels. In half-bridge mode A and the complement on B are separated by a programmable dead time. Each leg comes out as a pin level and a pin-enable, so a released leg can be handed back to general-purpose I/O.

Two polarity bits select active-low drive for the A/C pair and the B/D pair independently. Duty, period, configuration, steering, polarity and dead time are sampled together at the start of each timer period. Software may therefore rewrite them at any moment without producing a partial pulse.

Top module: `pwm_bridge_steer`

## Requirements
- R1: While reset is held and after it is released with all inputs zero, every pin level is 0 and every pin-enable is 0.
- R2: The duty value is {duty_hi_i, duty_lo_i}. The timer counts 0 up to the period value, so a period lasts period+1 clocks. The modulated signal is high for every count below the duty, which makes a steered leg active for exactly duty clocks per period.
- R3: When the duty is greater than or equal to the period value, the modulated signal is high for the whole period. A duty of 0 (with a non-zero period) keeps it low.
- R4: Configuration 00 (single) drives the modulated signal on each leg whose steer_i bit is 1 (bit 0 = A, 1 = B, 2 = C, 3 = D), with pin-enable 1. Every other leg has pin-enable 0 and level 0.
- R5: Configuration 01 (forward) enables all four legs: D carries the modulated signal, A is held active, and B and C are held inactive.
- R6: Configuration 11 (reverse) enables all four legs: B carries the modulated signal, C is held active, and A and D are held inactive.
- R7: Configuration 10 (half-bridge) drives A with the modulated signal and B with its complement, both enabled. C and D have pin-enable 0 and level 0.
- R8: In half-bridge mode each rising transition of A or B is delayed by dead_i clocks and falling transitions are not delayed. Per period A is active for duty−dead clocks and B for (period+1−duty)−dead clocks, and A and B are never active together.
- R9: pol_low_i bit 1 makes A and C active-low and bit 0 makes B and D active-low. Polarity is applied after steering and dead time, so an inactive but enabled leg sits at the inactive level of its polarity (1 for active-low).
- R10: Configuration, steering, polarity, dead time, duty and period take effect only at the clock where the timer count is 0. Changes made in the middle of a period leave the outputs unchanged until the next period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_cnt_i | input | 10 | Period timer count (timer plus prescale bits) |
| period_i | input | 10 | Last count of the period |
| duty_hi_i | input | 8 | Upper 8 bits of the duty value |
| duty_lo_i | input | 2 | Lower 2 bits of the duty value |
| bridge_cfg_i | input | 2 | 00 single, 01 forward, 10 half-bridge, 11 reverse |
| pol_low_i | input | 2 | Bit 1: A/C active-low; bit 0: B/D active-low |
| dead_i | input | 7 | Dead-time length in clocks (half-bridge) |
| steer_i | input | 4 | Leg selection mask for single mode |
| pin_o | output | 4 | Pin levels, bit 0 = A … bit 3 = D |
| pin_oe_o | output | 4 | Pin-enables, bit 0 = A … bit 3 = D |

## Verification
The assertions assume that the timer count wraps to 0 after it reaches the period value and never skips 0. The held-configuration property leans on zero being the only reload point, and the per-mode output properties assume that polarity and configuration are read through the shadow registers one clock before the output register. The bench drives the timer from its own counter with a fixed period and changes the control inputs only on falling edges. Except in the double-buffering test, it lets several whole periods pass after a change before it counts active clocks over one full period.

// File: rtl/pwm_steer_pkg.sv
// Shared encodings for the bridge PWM steering stage.
// Assumes: leg index 0 = A, 1 = B, 2 = C, 3 = D throughout.
package pwm_steer_pkg;

    typedef enum logic [1:0] {
        BR_SINGLE = 2'b00,
        BR_FWD    = 2'b01,
        BR_HALF   = 2'b10,
        BR_REV    = 2'b11
    } bridge_cfg_e;

    localparam int NUM_LEGS = 4;
    localparam int LEG_A    = 0;
    localparam int LEG_B    = 1;
    localparam int LEG_C    = 2;
    localparam int LEG_D    = 3;

endpackage

// File: rtl/pwm_shadow_regs.sv
// Shadow (double-buffer) registers for every control input.
// Loads all controls together on the clock where period_start is high,
// so a period always runs with one consistent set of settings.
// Assumes: period_start is high for exactly one clock per period.
module pwm_shadow_regs
    import pwm_steer_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int DB_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic [CNT_W-1:0]  duty_in,
    input  logic [CNT_W-1:0]  period_in,
    input  bridge_cfg_e       cfg_in,
    input  logic [1:0]        pol_in,
    input  logic [DB_W-1:0]   dead_in,
    input  logic [NUM_LEGS-1:0] steer_in,
    output logic [CNT_W-1:0]  duty_act,
    output logic [CNT_W-1:0]  period_act,
    output bridge_cfg_e       cfg_act,
    output logic [1:0]        pol_act,
    output logic [DB_W-1:0]   dead_act,
    output logic [NUM_LEGS-1:0] steer_act
);

    // Capture the pending settings at the start of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act   <= '0;
            period_act <= '0;
            cfg_act    <= BR_SINGLE;
            pol_act    <= '0;
            dead_act   <= '0;
            steer_act  <= '0;
        end else if (period_start) begin
            duty_act   <= duty_in;
            period_act <= period_in;
            cfg_act    <= cfg_in;
            pol_act    <= pol_in;
            dead_act   <= dead_in;
            steer_act  <= steer_in;
        end
    end

endmodule

// File: rtl/pwm_duty_cmp.sv
// Duty comparator: produces the registered modulated signal.
// High while the timer count is below the duty; high for the whole period
// when the duty reaches or exceeds the period value. On the reload clock
// it compares against the values being loaded, so the new period's first
// count already uses the new settings.
// Assumes: timer count restarts at 0 after the period value.
module pwm_duty_cmp #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_start,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic [CNT_W-1:0] duty_new,
    input  logic [CNT_W-1:0] period_new,
    input  logic [CNT_W-1:0] duty_act,
    input  logic [CNT_W-1:0] period_act,
    output logic             mod_q
);

    logic [CNT_W-1:0] duty_eff;
    logic [CNT_W-1:0] period_eff;
    logic             full_on;
    logic             mod_d;

    // Select the settings that govern the current count.
    always_comb begin
        duty_eff   = period_start ? duty_new   : duty_act;
        period_eff = period_start ? period_new : period_act;
        full_on    = (duty_eff >= period_eff);
        mod_d      = full_on || (tmr_cnt < duty_eff);
    end

    // Register the modulated signal.
    always_ff @(posedge clk) begin
        if (!rst_n) mod_q <= 1'b0;
        else        mod_q <= mod_d;
    end

endmodule

// File: rtl/pwm_dead_leg.sv
// One dead-time leg: delays each rising edge of its raw input by dead_len
// clocks and passes falling edges straight through.
// Assumes: dead_len is stable while raw is high (it only changes at period
// start, where a shorter value simply releases the leg earlier).
module pwm_dead_leg #(
    parameter int DB_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [DB_W-1:0] dead_len,
    output logic            leg
);

    logic [DB_W-1:0] wait_cnt;

    // Output is active once the raw input has been high for dead_len clocks.
    always_comb begin
        leg = raw && (wait_cnt >= dead_len);
    end

    // Count clocks since the raw input rose, saturating at dead_len.
    always_ff @(posedge clk) begin
        if (!rst_n)                   wait_cnt <= '0;
        else if (!raw)                wait_cnt <= '0;
        else if (wait_cnt < dead_len) wait_cnt <= wait_cnt + 1'b1;
    end

endmodule

// File: rtl/pwm_steer_out.sv
// Output stage: maps the modulated signal and dead-time legs onto the four
// legs for the selected bridge mode, applies per-pair polarity and registers
// the pin levels and pin-enables. Released legs are driven to level 0.
// Assumes: leg_a/leg_b are only meaningful in half-bridge mode.
module pwm_steer_out
    import pwm_steer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  bridge_cfg_e         cfg_act,
    input  logic [1:0]          pol_act,
    input  logic [NUM_LEGS-1:0] steer_act,
    input  logic                mod_q,
    input  logic                leg_a,
    input  logic                leg_b,
    output logic [NUM_LEGS-1:0] pin_o,
    output logic [NUM_LEGS-1:0] pin_oe_o
);

    logic [NUM_LEGS-1:0] active;
    logic [NUM_LEGS-1:0] enable;
    logic [NUM_LEGS-1:0] low_mask;
    logic [NUM_LEGS-1:0] level_d;

    // Decide which legs are driven and their active/inactive state.
    always_comb begin
        active = '0;
        enable = '0;
        unique case (cfg_act)
            BR_SINGLE: begin
                active = steer_act & {NUM_LEGS{mod_q}};
                enable = steer_act;
            end
            BR_FWD: begin
                active[LEG_A] = 1'b1;
                active[LEG_D] = mod_q;
                enable        = '1;
            end
            BR_REV: begin
                active[LEG_C] = 1'b1;
                active[LEG_B] = mod_q;
                enable        = '1;
            end
            BR_HALF: begin
                active[LEG_A] = leg_a;
                active[LEG_B] = leg_b;
                enable[LEG_A] = 1'b1;
                enable[LEG_B] = 1'b1;
            end
            default: begin
                active = '0;
                enable = '0;
            end
        endcase
    end

    // Apply pair polarity on enabled legs; released legs sit at 0.
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_pol
        localparam bit IS_AC = (g == LEG_A) || (g == LEG_C);
        always_comb begin
            low_mask[g] = IS_AC ? pol_act[1] : pol_act[0];
            level_d[g]  = enable[g] & (active[g] ^ low_mask[g]);
        end
    end

    // Register the pin levels and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o    <= '0;
            pin_oe_o <= '0;
        end else begin
            pin_o    <= level_d;
            pin_oe_o <= enable;
        end
    end

endmodule

// File: rtl/pwm_bridge_steer.sv
// Top of the bridge PWM steering stage.
// Shadow registers -> duty comparator -> two dead-time legs -> steering and
// polarity output register. Pin latency from timer count is two clocks.
// Assumes: the external timer counts 0..period_i and wraps to 0.
module pwm_bridge_steer
    import pwm_steer_pkg::*;
#(
    parameter int DUTY_HI_W = 8,
    parameter int DUTY_LO_W = 2,
    parameter int DB_W      = 7,
    localparam int CNT_W    = DUTY_HI_W + DUTY_LO_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     tmr_cnt_i,
    input  logic [CNT_W-1:0]     period_i,
    input  logic [DUTY_HI_W-1:0] duty_hi_i,
    input  logic [DUTY_LO_W-1:0] duty_lo_i,
    input  logic [1:0]           bridge_cfg_i,
    input  logic [1:0]           pol_low_i,
    input  logic [DB_W-1:0]      dead_i,
    input  logic [3:0]           steer_i,
    output logic [3:0]           pin_o,
    output logic [3:0]           pin_oe_o
);

    logic                period_start;
    logic [CNT_W-1:0]    duty_new;
    bridge_cfg_e         cfg_new;
    logic [CNT_W-1:0]    duty_act;
    logic [CNT_W-1:0]    period_act;
    bridge_cfg_e         cfg_act;
    logic [1:0]          pol_act;
    logic [DB_W-1:0]     dead_act;
    logic [NUM_LEGS-1:0] steer_act;
    logic                mod_q;
    logic [1:0]          leg_raw;
    logic [1:0]          leg_db;
    logic                leg_a;
    logic                leg_b;

    // Period start, concatenated duty and typed configuration.
    always_comb begin
        period_start = (tmr_cnt_i == '0);
        duty_new     = {duty_hi_i, duty_lo_i};
        cfg_new      = bridge_cfg_e'(bridge_cfg_i);
        leg_raw      = {~mod_q, mod_q};
        leg_a        = leg_db[0];
        leg_b        = leg_db[1];
    end

    pwm_shadow_regs #(.CNT_W(CNT_W), .DB_W(DB_W)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .duty_in      (duty_new),
        .period_in    (period_i),
        .cfg_in       (cfg_new),
        .pol_in       (pol_low_i),
        .dead_in      (dead_i),
        .steer_in     (steer_i),
        .duty_act     (duty_act),
        .period_act   (period_act),
        .cfg_act      (cfg_act),
        .pol_act      (pol_act),
        .dead_act     (dead_act),
        .steer_act    (steer_act)
    );

    pwm_duty_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .tmr_cnt      (tmr_cnt_i),
        .duty_new     (duty_new),
        .period_new   (period_i),
        .duty_act     (duty_act),
        .period_act   (period_act),
        .mod_q        (mod_q)
    );

    // Two dead-time legs: index 0 follows the modulated signal (A),
    // index 1 follows its complement (B).
    for (genvar g = 0; g < 2; g++) begin : g_leg
        pwm_dead_leg #(.DB_W(DB_W)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (leg_raw[g]),
            .dead_len (dead_act),
            .leg      (leg_db[g])
        );
    end

    pwm_steer_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_act   (cfg_act),
        .pol_act   (pol_act),
        .steer_act (steer_act),
        .mod_q     (mod_q),
        .leg_a     (leg_a),
        .leg_b     (leg_b),
        .pin_o     (pin_o),
        .pin_oe_o  (pin_oe_o)
    );

endmodule

// File: rtl/pwm_steer_chk.sv
// Assertion checker for pwm_bridge_steer, attached with bind below.
// Assumes the timer count returns to 0 once per period.
module pwm_steer_chk
    import pwm_steer_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_cnt_i,
    input  logic [1:0]       cfg_act,
    input  logic [1:0]       pol_act,
    input  logic [3:0]       steer_act,
    input  logic             leg_a,
    input  logic             leg_b,
    input  logic [3:0]       pin_o,
    input  logic [3:0]       pin_oe_o
);

    // R10: shadowed configuration moves only on the reload clock.
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_cnt_i != '0) |=> $stable(cfg_act));

    // R8: the two dead-time legs are never active together.
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg_a && leg_b));

    // R5 and R9: forward mode enables all legs, A active, B and C inactive.
    a_r5_fwd_levels: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_act) == BR_FWD) |->
            (pin_oe_o == 4'hF) && (pin_o[0] == ~$past(pol_act[1])) &&
            (pin_o[1] == $past(pol_act[0])) && (pin_o[2] == $past(pol_act[1])));

    // R6 and R9: reverse mode enables all legs, C active, A and D inactive.
    a_r6_rev_levels: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_act) == BR_REV) |->
            (pin_oe_o == 4'hF) && (pin_o[2] == ~$past(pol_act[1])) &&
            (pin_o[0] == $past(pol_act[1])) && (pin_o[3] == $past(pol_act[0])));

    // R7: half-bridge releases C and D at level 0.
    a_r7_half_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_act) == BR_HALF) |->
            (pin_oe_o == 4'b0011) && (pin_o[3:2] == 2'b00));

    // R4: single mode enables exactly the steered legs.
    a_r4_single_oe: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_act) == BR_SINGLE) |-> (pin_oe_o == $past(steer_act)));

    // R4 and R7: a released leg is always at level 0.
    a_r4_released_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_o & ~pin_oe_o) == 4'b0000));

endmodule

bind pwm_bridge_steer pwm_steer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_cnt_i (tmr_cnt_i),
    .cfg_act   (cfg_act),
    .pol_act   (pol_act),
    .steer_act (steer_act),
    .leg_a     (leg_a),
    .leg_b     (leg_b),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
);

// File: tb/tb_pwm_bridge_steer.sv
`timescale 1ns/1ps
module tb_pwm_bridge_steer;

    localparam int PER = 39;
    localparam int NP  = PER + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] tmr = '0;
    logic [9:0] period = 10'(PER);
    logic [7:0] duty_hi = '0;
    logic [1:0] duty_lo = '0;
    logic [1:0] cfg = '0;
    logic [1:0] pol = '0;
    logic [6:0] dead = '0;
    logic [3:0] steer = '0;
    logic [3:0] pin;
    logic [3:0] oe;

    int n_chk = 0;
    int n_err = 0;
    int cnt [4];
    int ovl;

    always #5 clk = ~clk;

    // Period timer: counts 0..period and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || tmr >= period) tmr <= '0;
        else                         tmr <= tmr + 1'b1;
    end

    pwm_bridge_steer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_cnt_i    (tmr),
        .period_i     (period),
        .duty_hi_i    (duty_hi),
        .duty_lo_i    (duty_lo),
        .bridge_cfg_i (cfg),
        .pol_low_i    (pol),
        .dead_i       (dead),
        .steer_i      (steer),
        .pin_o        (pin),
        .pin_oe_o     (oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Apply a setting on a falling edge and let several periods pass.
    task automatic setup(input logic [1:0] c, input int d, input logic [1:0] p,
                         input int dt, input logic [3:0] s);
        @(negedge clk);
        cfg = c; duty_hi = 8'(d >> 2); duty_lo = 2'(d); pol = p;
        dead = 7'(dt); steer = s;
        repeat (3 * NP) @(posedge clk);
    endtask

    // Count high clocks of each pin, and A/B overlap, over one full period.
    task automatic measure();
        for (int k = 0; k < 4; k++) cnt[k] = 0;
        ovl = 0;
        for (int i = 0; i < NP; i++) begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) if (pin[k]) cnt[k]++;
            if (pin[0] && pin[1]) ovl++;
        end
    endtask

    task automatic expect4(input string req, input int a, input int b,
                           input int c, input int d);
        measure();
        chk({req, " leg A"}, cnt[0], a);
        chk({req, " leg B"}, cnt[1], b);
        chk({req, " leg C"}, cnt[2], c);
        chk({req, " leg D"}, cnt[3], d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 pin levels in reset", int'(pin), 0);
        chk("R1 enables in reset", int'(oe), 0);
        rst_n = 1'b1;
        repeat (2 * NP) @(negedge clk);
        chk("R1 pin levels after reset", int'(pin), 0);
        chk("R1 enables after reset", int'(oe), 0);
    endtask

    task automatic t_single();
        setup(2'b00, 10, 2'b00, 0, 4'b0101);
        expect4("R4 single steer A,C", 10, 0, 10, 0);
        chk("R4 single enables", int'(oe), 4'b0101);
        setup(2'b00, 13, 2'b00, 0, 4'b0010);
        expect4("R2 duty low bits, steer B", 0, 13, 0, 0);
    endtask

    task automatic t_full();
        setup(2'b00, PER, 2'b00, 0, 4'b0001);
        expect4("R3 duty equal period", NP, 0, 0, 0);
        setup(2'b00, 600, 2'b00, 0, 4'b0001);
        expect4("R3 duty above period", NP, 0, 0, 0);
        setup(2'b00, 0, 2'b00, 0, 4'b0001);
        expect4("R3 duty zero", 0, 0, 0, 0);
    endtask

    task automatic t_bridge();
        setup(2'b01, 10, 2'b00, 0, 4'b0000);
        expect4("R5 forward", NP, 0, 0, 10);
        chk("R5 forward enables", int'(oe), 4'hF);
        setup(2'b11, 10, 2'b00, 0, 4'b0000);
        expect4("R6 reverse", 0, 10, NP, 0);
        chk("R6 reverse enables", int'(oe), 4'hF);
    endtask

    task automatic t_half();
        setup(2'b10, 10, 2'b00, 0, 4'b1111);
        expect4("R7 half no dead time", 10, NP - 10, 0, 0);
        chk("R7 half enables", int'(oe), 4'b0011);
        setup(2'b10, 10, 2'b00, 3, 4'b0000);
        expect4("R8 half dead time 3", 7, NP - 10 - 3, 0, 0);
        chk("R8 no A/B overlap", ovl, 0);
        setup(2'b10, 10, 2'b11, 3, 4'b0000);
        expect4("R9 half active-low, C/D released", NP - 7, 3 + 10, 0, 0);
    endtask

    task automatic t_pol();
        setup(2'b01, 10, 2'b01, 0, 4'b0000);
        expect4("R9 forward B/D active-low", NP, NP, 0, NP - 10);
        setup(2'b01, 10, 2'b10, 0, 4'b0000);
        expect4("R9 forward A/C active-low", 0, 0, NP, 10);
        setup(2'b11, 10, 2'b11, 0, 4'b0000);
        expect4("R9 reverse all active-low", NP, NP - 10, 0, NP);
    endtask

    task automatic t_buffer();
        int bad;
        setup(2'b01, 10, 2'b00, 0, 4'b0000);
        while (tmr != 10'd15) @(negedge clk);
        cfg = 2'b11; duty_hi = 8'd5; duty_lo = 2'd0;
        bad = 0;
        while (tmr != 10'(PER)) begin
            @(negedge clk);
            if (pin[0] !== 1'b1 || pin[2] !== 1'b0) bad++;
        end
        chk("R10 old config held until period end", bad, 0);
        while (tmr != 10'd5) @(negedge clk);
        chk("R10 new config after reload", int'(pin[2:0] & 3'b101), 4);
        expect4("R10 new duty after reload", 0, 20, NP, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_single();
        t_full();
        t_bridge();
        t_half();
        t_pol();
        t_buffer();
        report();
    end

endmodule